// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block is a byte-wide configuration register file reached through two I/O ports: one port selects a register number (the index), the other moves a byte to or from the selected register. A small window of register numbers is writable. Register number zero is a fixed identity byte. The rest of the index space reads back as all ones and ignores writes. The stored bytes leave the block on a flat bus, so that downstream memory-map and shadow-region decoders can use them. Each accepted write also raises a one-cycle change pulse that carries the register number and the new byte, which tells those decoders when to recompute.

Two more I/O ports cause side effects and move no data. Reading the gate port opens the A20 address gate and writing it closes the gate. Reading the reset port fires a soft CPU reset pulse. Both of these reads return 0xFF.

The host bus uses plain single-cycle strobes. There is no valid/ready handshake and no back-pressure, because every access completes in the cycle it is presented. Read data appears one cycle later and is marked by `io_rvalid`.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the index is 0x00, every writable register is 0x00, `a20_en` is 0, and `cpu_rst_pulse`, `cfg_upd` and `io_rvalid` are 0.
- R2: A write to the index port (0xEC) loads the index. A read of the index port returns the current index in the next cycle.
- R3: A write to the data port (0xED) while the index lies in 0x02..0x16, both ends included, stores the byte. Register n appears on `cfg_regs[(n-2)*8 +: 8]` in the next cycle and reads back through the data port.
- R4: A data-port write while the index lies outside 0x02..0x16 is discarded. It changes no register and raises no `cfg_upd`.
- R5: A data-port read returns 0xD6 when the index is 0x00, returns 0xFF for any other index outside 0x02..0x16, and returns the stored byte inside that window.
- R6: Each accepted data write raises `cfg_upd` for exactly the next cycle, with `cfg_upd_idx` carrying the register number and `cfg_upd_data` carrying the byte.
- R7: A write to the gate port (0xEE) clears `a20_en` from the next cycle. A read of the gate port sets `a20_en` from the next cycle.
- R8: A read of the reset port (0xEF) raises `cpu_rst_pulse` for exactly one cycle, the cycle after the read.
- R9: Reads of 0xEE and 0xEF return 0xFF with `io_rvalid` set, and they leave the register file unchanged.
- R10: Accesses to any address other than 0xEC..0xEF raise no `io_rvalid` and change no state.
- R11: When `io_rd` and `io_wr` are both high in one cycle, only the write takes effect. The read has no side effect and raises no `io_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid with io_rvalid |
| io_rvalid | output | 1 | Read data valid, one cycle after a decoded read |
| cfg_regs | output | NREG*8 | Writable registers; register LO_IDX+k at bits k*8 +: 8 |
| cfg_upd | output | 1 | One-cycle pulse after an accepted data write |
| cfg_upd_idx | output | 8 | Register number of the accepted write |
| cfg_upd_data | output | 8 | Byte of the accepted write |
| a20_en | output | 1 | A20 gate level, 1 = open |
| cpu_rst_pulse | output | 1 | One-cycle soft CPU reset request |

## Verification
The data port is tested with the index set to both window edges (0x02 and 0x16), to points just outside the window (0x01 and 0x17), to the identity register, and to 0xFF. These cases separate an off-by-one in the range check from a stuck or absent write path. Distinct bytes go to neighbouring registers, so that a misplaced field on the flat bus shows up as a wrong byte rather than a match. The gate port is tested by opening it, closing it, and strobing both read and write in the same cycle, which separates read-side from write-side handling and exposes the conflict priority. The reset pulse is checked in the cycle after the read and again one cycle later, to catch a stretched pulse.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [2:0] {
    PORT_NONE,
    PORT_IDX,
    PORT_DAT,
    PORT_GATE,
    PORT_RST
  } port_e;
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_ADDR  = 'hEC,
  parameter int DAT_ADDR  = 'hED,
  parameter int GATE_ADDR = 'hEE,
  parameter int RST_ADDR  = 'hEF
) (
  input  logic [ADDR_W-1:0] addr,
  output port_e             sel
);
  localparam logic [ADDR_W-1:0] A_IDX  = ADDR_W'(IDX_ADDR);
  localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(DAT_ADDR);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(GATE_ADDR);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(RST_ADDR);

  always_comb begin
    if (addr == A_IDX)       sel = PORT_IDX;
    else if (addr == A_DAT)  sel = PORT_DAT;
    else if (addr == A_GATE) sel = PORT_GATE;
    else if (addr == A_RST)  sel = PORT_RST;
    else                     sel = PORT_NONE;
  end
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile #(
  parameter int LO_IDX = 2,
  parameter int HI_IDX = 'h16,
  parameter int ID_VAL = 'hD6,
  localparam int NREG  = HI_IDX - LO_IDX + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_we,
  input  logic            dat_we,
  input  logic [7:0]      wdata,
  output logic [7:0]      index,
  output logic [NREG*8-1:0] regs_flat,
  output logic [7:0]      dat_rvalue,
  output logic            upd,
  output logic [7:0]      upd_idx,
  output logic [7:0]      upd_data
);
  localparam logic [7:0] LO_B = 8'(LO_IDX);
  localparam logic [7:0] HI_B = 8'(HI_IDX);
  localparam logic [7:0] ID_B = 8'(ID_VAL);

  logic in_win;
  assign in_win = (index >= LO_B) && (index <= HI_B);

  always_ff @(posedge clk) begin
    if (!rst_n) index <= 8'h00;
    else if (idx_we) index <= wdata;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_ent
    localparam logic [7:0] MY_IDX = 8'(LO_IDX + k);
    logic [7:0] ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n) ent_q <= 8'h00;
      else if (dat_we && index == MY_IDX) ent_q <= wdata;
    end
    assign regs_flat[k*8 +: 8] = ent_q;
  end

  always_comb begin
    dat_rvalue = 8'hFF;
    if (index == 8'h00) dat_rvalue = ID_B;
    for (int k = 0; k < NREG; k++) begin
      if (index == 8'(LO_IDX + k)) dat_rvalue = regs_flat[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd      <= 1'b0;
      upd_idx  <= 8'h00;
      upd_data <= 8'h00;
    end else begin
      upd <= dat_we && in_win;
      if (dat_we && in_win) begin
        upd_idx  <= index;
        upd_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/cfgp_sidefx.sv
module cfgp_sidefx (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_close,
  input  logic gate_open,
  input  logic rst_req,
  output logic a20_en,
  output logic cpu_rst_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a20_en        <= 1'b0;
      cpu_rst_pulse <= 1'b0;
    end else begin
      if (gate_close)     a20_en <= 1'b0;
      else if (gate_open) a20_en <= 1'b1;
      cpu_rst_pulse <= rst_req;
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_ADDR  = 'hEC,
  parameter int DAT_ADDR  = 'hED,
  parameter int GATE_ADDR = 'hEE,
  parameter int RST_ADDR  = 'hEF,
  parameter int LO_IDX    = 2,
  parameter int HI_IDX    = 'h16,
  parameter int ID_VAL    = 'hD6,
  localparam int NREG     = HI_IDX - LO_IDX + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic [NREG*8-1:0] cfg_regs,
  output logic              cfg_upd,
  output logic [7:0]        cfg_upd_idx,
  output logic [7:0]        cfg_upd_data,
  output logic              a20_en,
  output logic              cpu_rst_pulse
);
  port_e      sel;
  logic       rd_eff;
  logic [7:0] index;
  logic [7:0] dat_rvalue;

  assign rd_eff = io_rd && !io_wr;

  cfgp_decode #(
    .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR),
    .GATE_ADDR(GATE_ADDR), .RST_ADDR(RST_ADDR)
  ) u_dec (
    .addr(io_addr),
    .sel (sel)
  );

  cfgp_regfile #(
    .LO_IDX(LO_IDX), .HI_IDX(HI_IDX), .ID_VAL(ID_VAL)
  ) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_we    (io_wr && sel == PORT_IDX),
    .dat_we    (io_wr && sel == PORT_DAT),
    .wdata     (io_wdata),
    .index     (index),
    .regs_flat (cfg_regs),
    .dat_rvalue(dat_rvalue),
    .upd       (cfg_upd),
    .upd_idx   (cfg_upd_idx),
    .upd_data  (cfg_upd_data)
  );

  cfgp_sidefx u_fx (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_close   (io_wr && sel == PORT_GATE),
    .gate_open    (rd_eff && sel == PORT_GATE),
    .rst_req      (rd_eff && sel == PORT_RST),
    .a20_en       (a20_en),
    .cpu_rst_pulse(cpu_rst_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= 8'hFF;
    end else begin
      io_rvalid <= rd_eff && sel != PORT_NONE;
      if (rd_eff) begin
        unique case (sel)
          PORT_IDX: io_rdata <= index;
          PORT_DAT: io_rdata <= dat_rvalue;
          default:  io_rdata <= 8'hFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter int ADDR_W    = 16,
  parameter int DAT_ADDR  = 'hED,
  parameter int GATE_ADDR = 'hEE,
  parameter int RST_ADDR  = 'hEF,
  parameter int IDX_ADDR  = 'hEC,
  parameter int LO_IDX    = 2,
  parameter int HI_IDX    = 'h16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic              io_rvalid,
  input logic              cfg_upd,
  input logic [7:0]        cfg_upd_idx,
  input logic              a20_en,
  input logic              cpu_rst_pulse
);
  logic dec_hit;
  assign dec_hit = (io_addr >= ADDR_W'(IDX_ADDR)) && (io_addr <= ADDR_W'(RST_ADDR));

  assert_upd_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd |-> $past(io_wr && io_addr == ADDR_W'(DAT_ADDR)));
  assert_upd_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd |-> (cfg_upd_idx >= 8'(LO_IDX) && cfg_upd_idx <= 8'(HI_IDX)));
  assert_gate_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a20_en) |-> $past(io_rd && !io_wr && io_addr == ADDR_W'(GATE_ADDR)));
  assert_gate_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a20_en) |-> $past(io_wr && io_addr == ADDR_W'(GATE_ADDR)));
  assert_rst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_pulse |-> $past(io_rd && !io_wr && io_addr == ADDR_W'(RST_ADDR)));
  assert_rvalid_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_rd && !io_wr && dec_hit));
endmodule

bind cfg_index_port cfg_index_port_chk #(
  .ADDR_W(ADDR_W), .DAT_ADDR(DAT_ADDR), .GATE_ADDR(GATE_ADDR),
  .RST_ADDR(RST_ADDR), .IDX_ADDR(IDX_ADDR), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_rvalid(io_rvalid), .cfg_upd(cfg_upd), .cfg_upd_idx(cfg_upd_idx),
  .a20_en(a20_en), .cpu_rst_pulse(cpu_rst_pulse)
);

// File: tb/sim_cfg_index_port.sv
`timescale 1ns/1ps
module sim_cfg_index_port;
  localparam int NREG = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic io_rvalid;
  logic [NREG*8-1:0] cfg_regs;
  logic cfg_upd;
  logic [7:0] cfg_upd_idx, cfg_upd_data;
  logic a20_en, cpu_rst_pulse;

  int total = 0;
  int bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  cfg_index_port u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .cfg_regs(cfg_regs), .cfg_upd(cfg_upd), .cfg_upd_idx(cfg_upd_idx),
    .cfg_upd_data(cfg_upd_data), .a20_en(a20_en), .cpu_rst_pulse(cpu_rst_pulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_io(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_io(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  function automatic logic [7:0] reg_of(input int n);
    return cfg_regs[(n-2)*8 +: 8];
  endfunction

  task automatic t_reset;
    check(a20_en == 0, "R1 a20", a20_en, 0);
    check(cpu_rst_pulse == 0 && cfg_upd == 0 && io_rvalid == 0, "R1 pulses", {cpu_rst_pulse, cfg_upd, io_rvalid}, 0);
    check(cfg_regs == '0, "R1 regs", cfg_regs[31:0], 0);
    rd_io(16'hEC, rv);
    check(rv == 8'h00 && io_rvalid, "R1 index", rv, 0);
  endtask

  task automatic t_index;
    wr_io(16'hEC, 8'h5A);
    rd_io(16'hEC, rv);
    check(rv == 8'h5A && io_rvalid, "R2 index readback", rv, 8'h5A);
  endtask

  task automatic t_store;
    wr_io(16'hEC, 8'h02);
    wr_io(16'hED, 8'hA1);
    check(cfg_upd && cfg_upd_idx == 8'h02 && cfg_upd_data == 8'hA1, "R6 upd low edge", {cfg_upd, cfg_upd_idx, cfg_upd_data}, {1'b1, 8'h02, 8'hA1});
    @(negedge clk);
    check(!cfg_upd, "R6 upd one cycle", cfg_upd, 0);
    check(reg_of(2) == 8'hA1, "R3 reg 0x02", reg_of(2), 8'hA1);
    wr_io(16'hEC, 8'h03);
    wr_io(16'hED, 8'h3C);
    check(reg_of(3) == 8'h3C && reg_of(2) == 8'hA1, "R3 neighbour", {reg_of(3), reg_of(2)}, {8'h3C, 8'hA1});
    wr_io(16'hEC, 8'h16);
    wr_io(16'hED, 8'hE7);
    check(cfg_upd && cfg_upd_idx == 8'h16, "R6 upd high edge", cfg_upd_idx, 8'h16);
    check(reg_of(22) == 8'hE7, "R3 reg 0x16", reg_of(22), 8'hE7);
    rd_io(16'hED, rv);
    check(rv == 8'hE7 && io_rvalid, "R5 readback window", rv, 8'hE7);
  endtask

  task automatic t_discard;
    logic [NREG*8-1:0] snap;
    snap = cfg_regs;
    foreach (snap[i]) if (0) snap[i] = 1'b0;
    wr_io(16'hEC, 8'h01); wr_io(16'hED, 8'h77);
    check(!cfg_upd, "R4 idx 0x01 no upd", cfg_upd, 0);
    wr_io(16'hEC, 8'h17); wr_io(16'hED, 8'h77);
    check(!cfg_upd, "R4 idx 0x17 no upd", cfg_upd, 0);
    wr_io(16'hEC, 8'h00); wr_io(16'hED, 8'h11);
    check(!cfg_upd, "R4 idx 0x00 no upd", cfg_upd, 0);
    rd_io(16'hED, rv);
    check(rv == 8'hD6, "R5 identity", rv, 8'hD6);
    wr_io(16'hEC, 8'hFF); wr_io(16'hED, 8'h22);
    rd_io(16'hED, rv);
    check(rv == 8'hFF, "R5 unmapped index", rv, 8'hFF);
    check(cfg_regs == snap, "R4 regs unchanged", cfg_regs[31:0], snap[31:0]);
  endtask

  task automatic t_gate;
    rd_io(16'hEE, rv);
    check(a20_en == 1, "R7 open", a20_en, 1);
    check(rv == 8'hFF && io_rvalid, "R9 gate read", rv, 8'hFF);
    wr_io(16'hEE, 8'h00);
    check(a20_en == 0, "R7 close", a20_en, 0);
    rd_io(16'hEE, rv);
    @(negedge clk);
    io_addr = 16'hEE; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check(a20_en == 0 && !io_rvalid, "R11 write wins", {a20_en, io_rvalid}, 0);
  endtask

  task automatic t_reset_port;
    logic [NREG*8-1:0] snap;
    snap = cfg_regs;
    rd_io(16'hEF, rv);
    check(cpu_rst_pulse == 1, "R8 pulse", cpu_rst_pulse, 1);
    check(rv == 8'hFF && io_rvalid, "R9 reset read", rv, 8'hFF);
    @(negedge clk);
    check(cpu_rst_pulse == 0, "R8 one cycle", cpu_rst_pulse, 0);
    check(cfg_regs == snap, "R9 regs kept", cfg_regs[31:0], snap[31:0]);
  endtask

  task automatic t_undecoded;
    logic [NREG*8-1:0] snap;
    snap = cfg_regs;
    wr_io(16'hEC, 8'h05);
    wr_io(16'h01EC, 8'h09);
    wr_io(16'hED, 8'h44);
    check(cfg_upd_idx == 8'h05, "R10 alias write ignored", cfg_upd_idx, 8'h05);
    rd_io(16'hF0, rv);
    check(!io_rvalid, "R10 no rvalid", io_rvalid, 0);
    rd_io(16'h01EF, rv);
    check(!cpu_rst_pulse && !io_rvalid, "R10 alias read ignored", cpu_rst_pulse, 0);
    check(reg_of(5) == 8'h44, "R3 reg 0x05", reg_of(5), 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_store();
    t_discard();
    t_gate();
    t_reset_port();
    t_undecoded();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule